// File: doc/BRIEF.md
# Serial Register Bank Slave

This block is a two-wire serial slave that holds a bank of byte-wide control registers for the rest of the chip. It runs entirely on the system clock. The serial clock and data lines are treated as slow inputs: each passes through a two-flop synchroniser, and the sampled edges give the bit timing and the start and stop conditions. The only thing the block drives onto the bus is a single pull-low enable for the data line.

The bank has no register addressing. A write transfer carries the address byte and then two filler bytes, which are acknowledged and then thrown away. After those two bytes, the data bytes land in register 0, then register 1, and so on until the stop condition. A read transfer returns register 0, then register 1, and so on, starting right after the address acknowledge. It keeps going until the master declines a byte.

Two kinds of register position cannot be written. One position mirrors a live status input. Two positions hold fixed identification values. Writes to any of these are acknowledged and discarded. A pointer that runs past the end of the bank stops there: further writes are discarded and further reads return zero.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset, every register output carries its power-up default and the data-line pull-low output is 0. The defaults are: registers 0..4 = 0x00, 5 = 0xCF, 6 = 0xFF, 7 = 0xFF, 9 = 0xE0, 10 = 0x00, 11 = 0x40, 12..14 = 0x00.
- R2: An address byte whose upper seven bits are 1101001 is acknowledged: the data line is pulled low during the ninth clock. Bit 0 of that byte selects the direction, with 0xD2 meaning write and 0xD3 meaning read.
- R3: An address byte with any other seven-bit value is not acknowledged. After it, the slave ignores every bit and leaves every register unchanged until the next start condition.
- R4: In a write transfer, the two bytes that follow the address are acknowledged and their contents never reach any register.
- R5: In a write transfer, each byte after those two is acknowledged and stored in the next register position in turn, starting at position 0, until the stop condition.
- R6: A read transfer returns the register contents in position order, starting at position 0 and continuing with the first byte right after the address acknowledge. Each byte is sent most significant bit first.
- R7: When the master does not acknowledge a read byte, the slave releases the data line and leaves it released until the next start condition.
- R8: A repeated start in the middle of a transfer restarts address decoding, and the new transfer begins again at position 0.
- R9: Position 8 always shows the status input. Positions 15 and 16 always hold 0x62 and 0xA1. Writes to these three positions are acknowledged and discarded.
- R10: Data bytes written past the last position (16) are acknowledged and discarded. Read bytes past the last position return 0x00.
- R11: The pull-low output changes only while the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-up reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| statusIn | input | 8 | Live status byte shown at position 8 |
| sdaPullLow | output | 1 | 1 pulls the data line low |
| regOut | output | NUM_REGS*8 | All register positions, with position i on bits [8i+7:8i] |

## Verification
The write of a data byte and the saturation of the position pointer can fall in the same cycle. This happens when the byte aimed at position 16, or at any position past it, is accepted: the same strobe must discard the byte and hold the pointer. The bench provokes this by streaming nineteen data bytes in one transfer and then reading nineteen bytes back. It judges the result from the acknowledges, from the identification bytes, which must be unchanged, and from the two trailing reads, which must both return zero. A live change of the status input between the write and the read also checks that position 8 is merged at readback time.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef struct packed {
    logic       ptrClr;
    logic       ptrInc;
    logic       wrEn;
    logic [7:0] wrData;
  } ctrlStrb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RXACK,
    ST_TX,
    ST_TXACK
  } slvState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_CNT,
    K_DATA
  } byteKind_t;

endpackage

// File: rtl/i2cSlvCtrl.sv
module i2cSlvCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdData,
  output ctrlStrb_t  strb,
  output logic       sdaPullLow
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sclSyn, sdaSyn;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, startCond, stopCond;

  slvState_t  state;
  byteKind_t  kind;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic       isRead, mAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSyn  <= '1;
      sdaSyn  <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSyn  <= {sclSyn[SYNC_STAGES-2:0], sclIn};
      sdaSyn  <= {sdaSyn[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSyn[SYNC_STAGES-1];
      sdaPrev <= sdaSyn[SYNC_STAGES-1];
    end
  end

  assign sclNow    = sclSyn[SYNC_STAGES-1];
  assign sdaNow    = sdaSyn[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startCond = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopCond  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  function automatic byteKind_t nextKind(byteKind_t k);
    case (k)
      K_ADDR:  return K_CMD;
      K_CMD:   return K_CNT;
      default: return K_DATA;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= K_ADDR;
      bitCnt     <= '0;
      rxShift    <= '0;
      txShift    <= '0;
      isRead     <= 1'b0;
      mAck       <= 1'b0;
      sdaPullLow <= 1'b0;
      strb       <= '0;
    end else begin
      strb <= '0;
      if (startCond) begin
        state      <= ST_RX;
        kind       <= K_ADDR;
        bitCnt     <= '0;
        sdaPullLow <= 1'b0;
      end else if (stopCond) begin
        state      <= ST_IDLE;
        sdaPullLow <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt != 4'd8) begin
              rxShift <= {rxShift[6:0], sdaNow};
              bitCnt  <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (kind == K_ADDR && rxShift[7:1] != SLAVE_ADDR) begin
                state <= ST_IDLE;
              end else begin
                state      <= ST_RXACK;
                sdaPullLow <= 1'b1;
                if (kind == K_ADDR) begin
                  isRead      <= rxShift[0];
                  strb.ptrClr <= 1'b1;
                end
                if (kind == K_DATA) begin
                  strb.wrEn   <= 1'b1;
                  strb.wrData <= rxShift;
                end
              end
            end
          end
          ST_RXACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (kind == K_ADDR && isRead) begin
                state      <= ST_TX;
                txShift    <= rdData;
                sdaPullLow <= ~rdData[7];
              end else begin
                state      <= ST_RX;
                sdaPullLow <= 1'b0;
                kind       <= nextKind(kind);
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                state       <= ST_TXACK;
                sdaPullLow  <= 1'b0;
                strb.ptrInc <= 1'b1;
              end else begin
                bitCnt     <= bitCnt + 4'd1;
                txShift    <= {txShift[6:0], 1'b0};
                sdaPullLow <= ~txShift[6];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) mAck <= ~sdaNow;
            if (sclFall) begin
              if (mAck) begin
                state      <= ST_TX;
                bitCnt     <= '0;
                txShift    <= rdData;
                sdaPullLow <= ~rdData[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cRegDatapath.sv
module i2cRegDatapath
  import i2cRegPkg::*;
#(
  parameter int                      NUM_REGS     = 17,
  parameter int                      STATUS_IDX   = 8,
  parameter logic [NUM_REGS-1:0]     WR_MASK      = 17'h07EFF,
  parameter logic [NUM_REGS*8-1:0]   RESET_VALUES = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [7:0]            statusIn,
  output logic [7:0]            rdData,
  output logic [NUM_REGS*8-1:0] regOut
);

  localparam int PTR_W = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrClr) begin
      ptr <= '0;
    end else if ((strb.wrEn || strb.ptrInc) && ptr != PTR_END) begin
      ptr <= ptr + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == STATUS_IDX) begin : g_status
      assign regOut[i*8 +: 8] = statusIn;
    end else if (WR_MASK[i]) begin : g_rw
      logic [7:0] regByte;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          regByte <= RESET_VALUES[i*8 +: 8];
        else if (strb.wrEn && ptr == PTR_W'(i))
          regByte <= strb.wrData;
      end
      assign regOut[i*8 +: 8] = regByte;
    end else begin : g_ro
      assign regOut[i*8 +: 8] = RESET_VALUES[i*8 +: 8];
    end
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ptr == PTR_W'(i)) rdData = regOut[i*8 +: 8];
    end
  end

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter int                    NUM_REGS     = 17,
  parameter logic [6:0]            SLAVE_ADDR   = 7'h69,
  parameter int                    STATUS_IDX   = 8,
  parameter logic [NUM_REGS-1:0]   WR_MASK      = 17'h07EFF,
  parameter logic [NUM_REGS*8-1:0] RESET_VALUES = {
    8'hA1, 8'h62, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 8'hE0, 8'h00,
    8'hFF, 8'hFF, 8'hCF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [7:0]            statusIn,
  output logic                  sdaPullLow,
  output logic [NUM_REGS*8-1:0] regOut
);

  ctrlStrb_t  ctrlStrb;
  logic [7:0] rdData;

  i2cSlvCtrl #(
    .SLAVE_ADDR(SLAVE_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .rdData    (rdData),
    .strb      (ctrlStrb),
    .sdaPullLow(sdaPullLow)
  );

  i2cRegDatapath #(
    .NUM_REGS    (NUM_REGS),
    .STATUS_IDX  (STATUS_IDX),
    .WR_MASK     (WR_MASK),
    .RESET_VALUES(RESET_VALUES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (ctrlStrb),
    .statusIn(statusIn),
    .rdData  (rdData),
    .regOut  (regOut)
  );

endmodule

// File: rtl/i2cRegSlaveChk.sv
module i2cRegSlaveChk
  import i2cRegPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullLow,
  input ctrlStrb_t  strb,
  input logic [7:0] regByte0
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rstN |-> !sdaPullLow);

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclIn);

  assert_strobe_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrClr, strb.ptrInc, strb.wrEn}));

  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> sdaPullLow);

  assert_reg_only_by_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regByte0) |-> $past(strb.wrEn));

  assert_read_step_released_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrInc |-> !sdaPullLow);

endmodule

bind i2cRegSlave i2cRegSlaveChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaPullLow(sdaPullLow),
  .strb      (ctrlStrb),
  .regByte0  (regOut[7:0])
);

// File: tb/tb_i2cRegSlave.sv
`timescale 1ns/1ps
module tb_i2cRegSlave;

  localparam int NREG = 17;
  localparam int Q    = 20;
  localparam int STAT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mSda = 1'b1;
  logic [7:0] statusIn = 8'h5B;
  logic sdaPullLow;
  logic [NREG*8-1:0] regOut;
  logic busSda;

  assign busSda = mSda & ~sdaPullLow;

  always #2.5 clk = ~clk;

  i2cRegSlave dut (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (scl),
    .sdaIn     (busSda),
    .statusIn  (statusIn),
    .sdaPullLow(sdaPullLow),
    .regOut    (regOut)
  );

  int checks = 0;
  int errors = 0;
  int oeHighChanges = 0;
  logic prevOe = 1'b0;
  logic [7:0] expReg [NREG];

  always @(negedge clk) begin
    if (scl && rstN && (sdaPullLow !== prevOe)) oeHighChanges++;
    prevOe = sdaPullLow;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2cStart();
    mSda = 1'b1; waitQ();
    scl  = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    scl  = 1'b0; waitQ();
  endtask

  task automatic i2cStop();
    mSda = 1'b0; waitQ();
    scl  = 1'b1; waitQ();
    mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ();
      scl = 1'b1; waitQ(); waitQ();
      scl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    ack = ~busSda; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] d);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      d[i] = busSda; waitQ();
      scl = 1'b0; waitQ();
    end
    mSda = ~giveAck; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  function automatic logic [7:0] expRead(input int idx);
    if (idx >= NREG) return 8'h00;
    if (idx == STAT) return statusIn;
    return expReg[idx];
  endfunction

  task automatic checkRegs(input string tag);
    for (int i = 0; i < NREG; i++)
      check($sformatf("%s reg%0d", tag, i), 32'(regOut[i*8 +: 8]), 32'(expRead(i)));
  endtask

  task automatic testReset();
    check("R1 pull-low after reset", 32'(sdaPullLow), 32'd0);
    checkRegs("R1 default");
  endtask

  task automatic testFillerOnly();
    logic a0, a1, a2;
    i2cStart();
    sendByte(8'hD2, a0);
    sendByte(8'h5A, a1);
    sendByte(8'h03, a2);
    i2cStop();
    check("R2 write address ack", 32'(a0), 32'd1);
    check("R4 command byte ack", 32'(a1), 32'd1);
    check("R4 count byte ack", 32'(a2), 32'd1);
    checkRegs("R4 fillers ignored");
  endtask

  task automatic testWrite3();
    logic a;
    logic allAck = 1'b1;
    logic [7:0] vals [3] = '{8'h11, 8'h22, 8'h33};
    i2cStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'h00, a); allAck &= a;
    sendByte(8'h00, a); allAck &= a;
    for (int i = 0; i < 3; i++) begin
      sendByte(vals[i], a); allAck &= a;
      expReg[i] = vals[i];
    end
    i2cStop();
    check("R5 all bytes acked", 32'(allAck), 32'd1);
    checkRegs("R5 sequential write");
  endtask

  task automatic testRead4();
    logic a;
    logic [7:0] d;
    int lowSeen = 0;
    i2cStart();
    sendByte(8'hD3, a);
    check("R2 read address ack", 32'(a), 32'd1);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, d);
      check($sformatf("R6 read byte %0d", i), 32'(d), 32'(expRead(i)));
    end
    for (int i = 0; i < 9; i++) begin
      waitQ();
      scl = 1'b1; waitQ();
      if (!busSda) lowSeen++;
      waitQ();
      scl = 1'b0; waitQ();
    end
    check("R7 released after master nack", 32'(lowSeen), 32'd0);
    i2cStop();
  endtask

  task automatic testWrongAddr();
    logic a0, a1;
    i2cStart();
    sendByte(8'hA4, a0);
    sendByte(8'h77, a1);
    sendByte(8'h77, a1);
    sendByte(8'h77, a1);
    i2cStop();
    check("R3 foreign address nack", 32'(a0), 32'd0);
    check("R3 later byte nack", 32'(a1), 32'd0);
    checkRegs("R3 registers untouched");
  endtask

  task automatic testFullStream();
    logic a;
    logic allAck = 1'b1;
    logic [7:0] d;
    i2cStart();
    sendByte(8'hD2, a); allAck &= a;
    sendByte(8'hFF, a); allAck &= a;
    sendByte(8'hFF, a); allAck &= a;
    for (int i = 0; i < NREG + 2; i++) begin
      sendByte(8'hC0 + 8'(i), a); allAck &= a;
      if (i < NREG && i != STAT && i != 15 && i != 16) expReg[i] = 8'hC0 + 8'(i);
    end
    i2cStop();
    check("R10 every byte acked incl. past end", 32'(allAck), 32'd1);
    checkRegs("R9 read-only kept");
    statusIn = 8'h3C;
    repeat (4) @(negedge clk);
    i2cStart();
    sendByte(8'hD3, a);
    for (int i = 0; i < NREG + 2; i++) begin
      recvByte(i != NREG + 1, d);
      if (i == STAT || i == 15 || i == 16)
        check($sformatf("R9 readback pos %0d", i), 32'(d), 32'(expRead(i)));
      else if (i >= NREG)
        check($sformatf("R10 readback past end %0d", i), 32'(d), 32'h00);
      else
        check($sformatf("R6 readback pos %0d", i), 32'(d), 32'(expRead(i)));
    end
    i2cStop();
  endtask

  task automatic testRepeatedStart();
    logic a;
    logic [7:0] d;
    i2cStart();
    sendByte(8'hD2, a);
    sendByte(8'h00, a);
    sendByte(8'h01, a);
    sendByte(8'h44, a);
    expReg[0] = 8'h44;
    i2cStart();
    sendByte(8'hD3, a);
    check("R8 address ack after repeated start", 32'(a), 32'd1);
    recvByte(1'b1, d);
    check("R8 first byte from position 0", 32'(d), 32'h44);
    recvByte(1'b0, d);
    check("R8 second byte from position 1", 32'(d), 32'(expRead(1)));
    i2cStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) expReg[i] = 8'h00;
    expReg[5]  = 8'hCF;
    expReg[6]  = 8'hFF;
    expReg[7]  = 8'hFF;
    expReg[9]  = 8'hE0;
    expReg[11] = 8'h40;
    expReg[15] = 8'h62;
    expReg[16] = 8'hA1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testFillerOnly();
    testWrite3();
    testRead4();
    testWrongAddr();
    testFullStream();
    testRepeatedStart();
    check("R11 pull-low changes while clock high", 32'(oeHighChanges), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule